// File: doc/BRIEF.md
# Memory-Type Range Register File

This block stores the registers that give physical memory regions their caching types. There are eight pairs of variable-range registers, each pair a base and a mask. There are also three groups of fixed-range registers: one covering 64K units, two covering 16K units and eight covering 4K units. The block also holds a default-type register, a page-attribute table and a read-only capability word. Every stored register is 64 bits wide and is reached through a single indexed request port. The port takes one request per cycle, which is either a read or a write.

Each write is checked before it can change any state. The block checks every memory-type byte against the legal encodings and checks each register's reserved fields and physical-address limit. A write that fails a check leaves all stored state unchanged and returns an error on the response. Each request gets exactly one response, one cycle after it is sampled. Translating addresses into memory types is done elsewhere; this block only holds and validates the register values.

Top module: `mtr_regfile`

## Requirements
- R1: After reset every stored register is zero, and `rsp_valid`, `rsp_error` and `rsp_rdata` are low.
- R2: A request sampled on a rising edge with `req_valid` high produces `rsp_valid` high for exactly the following cycle. No response appears without a request. A read returns the stored value, including every write accepted earlier, even one accepted in the immediately preceding cycle.
- R3: Index 0 is the capability word. It always reads as 0x0000000000000508, and every write to it is rejected.
- R4: The legal range memory types are the byte values 0x00, 0x01, 0x04, 0x05 and 0x06. A fixed-range write is accepted only if all eight bytes of the value are legal range types.
- R5: A page-attribute-table write is accepted only if all eight bytes are legal range types or 0x07.
- R6: A variable-base write is accepted only if bits 11:8 are zero, bits 7:0 are a legal range type, and every bit at or above PHYS_BITS (default 36) is zero.
- R7: A variable-mask write is accepted only if bits 10:0 are zero and every bit at or above PHYS_BITS is zero.
- R8: A default-type write is accepted only if bits 63:32 are zero, the value ANDed with 0xFFFFF300 is zero, and bits 7:0 are a legal range type. Only bits 31:0 are kept.
- R9: A rejected write raises `rsp_error` on its one response cycle and changes no stored register.
- R10: The index map is as follows. 1 is the default type. 2 is the attribute table. 3 is the 64K fixed register. 4 and 5 are the 16K fixed registers. 8 to 15 are the 4K fixed registers. 16 to 31 are the variable registers, where index 16+2n is base n and index 17+2n is mask n. Any other index is rejected with an error on both read and write, and a read of such an index returns zero.
- R11: An accepted write responds with `rsp_error` low and `rsp_rdata` zero. A read of a mapped index responds with `rsp_error` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 5 | Register index |
| req_wdata | input | 64 | Write value |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_error | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read value, zero for writes and errors |

## Verification
Two things can fall in the same cycle. One is the commit of an accepted write. The other is the sampling of a read of that same register, issued in the very next cycle, while the write's response is still on the port. The bench issues such write/read pairs with no gap between them, and also after rejected writes. The scoreboard expects the read to return the new value after an accepted write and the old value after a rejected one. Each response is matched in order against a shadow model that is updated only by writes the requirements allow.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int unsigned IDX_W     = 5;
    localparam int unsigned DATA_W    = 64;
    localparam int unsigned SUB_W     = 3;
    localparam logic [63:0] CAP_VALUE = 64'h0000_0000_0000_0508;
    localparam logic [7:0]  MT_UCM    = 8'h07;
    localparam logic [31:0] DEF_RSVD  = 32'hFFFF_F300;
    localparam int unsigned VAR_FIRST = 16;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_CAP,
        RK_DEF,
        RK_PAT,
        RK_FIX64,
        RK_FIX16,
        RK_FIX4,
        RK_VBASE,
        RK_VMASK
    } reg_kind_e;

    function automatic logic range_type_ok(input logic [7:0] t);
        return (t == 8'h00) || (t == 8'h01) || (t == 8'h04) ||
               (t == 8'h05) || (t == 8'h06);
    endfunction

endpackage

// File: rtl/mtr_type_check.sv
module mtr_type_check
    import mtr_pkg::*;
#(
    parameter bit ALLOW_UCM = 1'b0
) (
    input  logic [DATA_W-1:0] value,
    output logic              all_ok
);
    localparam int unsigned NBYTES = DATA_W / 8;

    logic [NBYTES-1:0] byte_ok;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] field;
        assign field = value[8*b +: 8];
        if (ALLOW_UCM) begin : g_ucm
            assign byte_ok[b] = range_type_ok(field) || (field == MT_UCM);
        end else begin : g_plain
            assign byte_ok[b] = range_type_ok(field);
        end
    end

    assign all_ok = &byte_ok;

endmodule

// File: rtl/mtr_index_decode.sv
module mtr_index_decode
    import mtr_pkg::*;
#(
    parameter int unsigned NVAR = 8
) (
    input  logic [IDX_W-1:0] idx,
    output reg_kind_e        kind,
    output logic [SUB_W-1:0] sub
);
    localparam int unsigned VAR_LAST = VAR_FIRST + 2 * NVAR - 1;

    always_comb begin
        kind = RK_NONE;
        sub  = '0;
        if (idx == 5'd0) begin
            kind = RK_CAP;
        end else if (idx == 5'd1) begin
            kind = RK_DEF;
        end else if (idx == 5'd2) begin
            kind = RK_PAT;
        end else if (idx == 5'd3) begin
            kind = RK_FIX64;
        end else if (idx == 5'd4 || idx == 5'd5) begin
            kind = RK_FIX16;
            sub  = {2'b00, idx[0]};
        end else if (idx >= 5'd8 && idx <= 5'd15) begin
            kind = RK_FIX4;
            sub  = idx[2:0];
        end else if (32'(idx) >= VAR_FIRST && 32'(idx) <= VAR_LAST) begin
            kind = idx[0] ? RK_VMASK : RK_VBASE;
            sub  = idx[3:1];
        end
    end

endmodule

// File: rtl/mtr_regfile.sv
module mtr_regfile
    import mtr_pkg::*;
#(
    parameter int unsigned PHYS_BITS = 36,
    parameter int unsigned NVAR      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [63:0]       rsp_rdata
);
    localparam int unsigned NVREG  = 2 * NVAR;
    localparam int unsigned NFIX4  = 8;
    localparam int unsigned NFIX16 = 2;

    typedef struct packed {
        logic [NVREG-1:0][63:0]  vr;
        logic [NFIX4-1:0][63:0]  fix4;
        logic [NFIX16-1:0][63:0] fix16;
        logic [63:0]             fix64;
        logic [63:0]             pat;
        logic [31:0]             deftype;
    } regs_t;

    typedef struct packed {
        regs_t       regs;
        logic        rsp_valid;
        logic        rsp_error;
        logic [63:0] rsp_rdata;
    } state_t;

    state_t    state_d, state_q;
    reg_kind_e kind;
    logic [SUB_W-1:0] sub;
    logic      fixed_ok, pat_ok, phys_ok, base_ok, mask_ok, def_ok;
    logic      wr_ok;
    logic [63:0] rd_val;
    logic      rd_hit;
    int unsigned vsel;

    mtr_index_decode #(.NVAR(NVAR)) u_decode (
        .idx  (req_index),
        .kind (kind),
        .sub  (sub)
    );

    mtr_type_check #(.ALLOW_UCM(1'b0)) u_chk_range (
        .value  (req_wdata),
        .all_ok (fixed_ok)
    );

    mtr_type_check #(.ALLOW_UCM(1'b1)) u_chk_pat (
        .value  (req_wdata),
        .all_ok (pat_ok)
    );

    if (PHYS_BITS < 64) begin : g_phys_limit
        assign phys_ok = ~|req_wdata[63:PHYS_BITS];
    end else begin : g_phys_full
        assign phys_ok = 1'b1;
    end

    assign base_ok = phys_ok && (req_wdata[11:8] == 4'h0) && range_type_ok(req_wdata[7:0]);
    assign mask_ok = phys_ok && (req_wdata[10:0] == 11'h000);
    assign def_ok  = (req_wdata[63:32] == 32'h0) &&
                     ((req_wdata[31:0] & DEF_RSVD) == 32'h0) &&
                     range_type_ok(req_wdata[7:0]);

    assign vsel = 2 * 32'(sub) + ((kind == RK_VMASK) ? 1 : 0);

    always_comb begin
        wr_ok = 1'b0;
        unique case (kind)
            RK_DEF:                     wr_ok = def_ok;
            RK_PAT:                     wr_ok = pat_ok;
            RK_FIX64, RK_FIX16, RK_FIX4: wr_ok = fixed_ok;
            RK_VBASE:                   wr_ok = base_ok;
            RK_VMASK:                   wr_ok = mask_ok;
            default:                    wr_ok = 1'b0;
        endcase
    end

    always_comb begin
        rd_val = '0;
        rd_hit = 1'b1;
        unique case (kind)
            RK_CAP:             rd_val = CAP_VALUE;
            RK_DEF:             rd_val = {32'h0, state_q.regs.deftype};
            RK_PAT:             rd_val = state_q.regs.pat;
            RK_FIX64:           rd_val = state_q.regs.fix64;
            RK_FIX16:           rd_val = state_q.regs.fix16[sub[0]];
            RK_FIX4:            rd_val = state_q.regs.fix4[sub];
            RK_VBASE, RK_VMASK: rd_val = state_q.regs.vr[vsel];
            default: begin
                rd_val = '0;
                rd_hit = 1'b0;
            end
        endcase
    end

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = req_valid;
        state_d.rsp_error = 1'b0;
        state_d.rsp_rdata = '0;
        if (req_valid) begin
            if (req_write) begin
                state_d.rsp_error = !wr_ok;
                if (wr_ok) begin
                    unique case (kind)
                        RK_DEF:   state_d.regs.deftype          = req_wdata[31:0];
                        RK_PAT:   state_d.regs.pat              = req_wdata;
                        RK_FIX64: state_d.regs.fix64            = req_wdata;
                        RK_FIX16: state_d.regs.fix16[sub[0]]    = req_wdata;
                        RK_FIX4:  state_d.regs.fix4[sub]        = req_wdata;
                        RK_VBASE, RK_VMASK: state_d.regs.vr[vsel] = req_wdata;
                        default: ;
                    endcase
                end
            end else begin
                state_d.rsp_error = !rd_hit;
                state_d.rsp_rdata = rd_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_error = state_q.rsp_error;
    assign rsp_rdata = state_q.rsp_rdata;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    reject_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !wr_ok) |=> (state_q.regs == $past(state_q.regs)));

    // R10
    error_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> rsp_valid);

    // R3
    cap_read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && kind == RK_CAP) |=> (rsp_rdata == CAP_VALUE && !rsp_error));

    // R8
    deftype_rsvd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.regs.deftype & DEF_RSVD) == 32'h0);

    for (genvar v = 0; v < NVAR; v++) begin : g_mask_chk
        // R7
        mask_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            state_q.regs.vr[2*v+1][10:0] == 11'h000);
    end

endmodule

// File: tb/mtr_regfile_tb.sv
`timescale 1ns/1ps
module mtr_regfile_tb;

    typedef struct {
        logic [63:0] data;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_index = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_error;
    logic [63:0] rsp_rdata;

    exp_t        sb[$];
    logic [63:0] shadow [32];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    mtr_regfile u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_index (req_index),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_error (rsp_error),
        .rsp_rdata (rsp_rdata)
    );

    function automatic bit mapped(input int idx);
        return (idx >= 1 && idx <= 5) || (idx >= 8);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic act_e, input logic [63:0] exp, input logic exp_e);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got rdata=%h err=%b, expected rdata=%h err=%b",
                     tag, act, act_e, exp, exp_e);
        end
    endtask

    task automatic issue(input logic wr, input int idx, input logic [63:0] data,
                         input logic exp_err, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_index = idx[4:0];
        req_wdata = data;
        e.tag = tag;
        e.err = exp_err;
        if (wr) begin
            e.data = '0;
            if (!exp_err) shadow[idx] = data;
        end else begin
            e.data = (idx == 0) ? 64'h508 : shadow[idx];
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected response", rsp_rdata, rsp_error, '0, 1'b0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_rdata === e.data && rsp_error === e.err, e.tag,
                      rsp_rdata, rsp_error, e.data, e.err);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", '0, 1'b0, '0, 1'b0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_error === 1'b0 && rsp_rdata === 64'h0,
              "R1 outputs in reset", rsp_rdata, rsp_error, '0, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // R1 / R10: read every index after reset
        for (int i = 0; i < 32; i++) issue(1'b0, i, '0, !(i == 0 || mapped(i)), "R1 R10 reset read");
        idle(2);

        // R3
        issue(1'b1, 0, 64'h0606, 1'b1, "R3 cap write rejected");
        issue(1'b0, 0, '0, 1'b0, "R3 cap read");

        // R4 / R11
        issue(1'b1, 3, 64'h0606_0505_0404_0100, 1'b0, "R4 R11 fix64 legal write");
        issue(1'b0, 3, '0, 1'b0, "R2 R4 fix64 readback");
        issue(1'b1, 11, 64'h0000_0000_0000_0700, 1'b1, "R4 fix4 ucm rejected");
        issue(1'b0, 11, '0, 1'b0, "R9 fix4 unchanged");
        issue(1'b1, 5, 64'h0206_0606_0606_0606, 1'b1, "R4 fix16 top byte 0x02");
        issue(1'b1, 4, 64'h0101_0101_0404_0505, 1'b0, "R4 fix16 legal");
        issue(1'b0, 4, '0, 1'b0, "R4 fix16 readback");
        issue(1'b0, 5, '0, 1'b0, "R9 fix16 other unchanged");
        issue(1'b1, 15, 64'h0600_0600_0600_0601, 1'b0, "R4 last fix4 legal");
        issue(1'b0, 15, '0, 1'b0, "R4 last fix4 readback");

        // R5
        issue(1'b1, 2, 64'h0007_0605_0401_0007, 1'b0, "R5 pat with ucm");
        issue(1'b0, 2, '0, 1'b0, "R5 pat readback");
        issue(1'b1, 2, 64'h0800_0000_0000_0000, 1'b1, "R5 pat 0x08 rejected");
        issue(1'b0, 2, '0, 1'b0, "R9 pat unchanged");

        // R6
        issue(1'b1, 16, 64'h0000_000F_FFFF_F006, 1'b0, "R6 base legal");
        issue(1'b0, 16, '0, 1'b0, "R6 base readback");
        issue(1'b1, 16, 64'h0000_0010_0000_0006, 1'b1, "R6 base above phys");
        issue(1'b1, 16, 64'h0000_0000_0000_0106, 1'b1, "R6 base bit8 set");
        issue(1'b1, 16, 64'h0000_0000_0000_0003, 1'b1, "R6 base type 0x03");
        issue(1'b0, 16, '0, 1'b0, "R9 base unchanged");

        // R7
        issue(1'b1, 17, 64'h0000_000F_FFFF_F800, 1'b0, "R7 mask legal");
        issue(1'b1, 17, 64'h0000_000F_FFFF_FC00, 1'b1, "R7 mask bit10 set");
        issue(1'b1, 17, 64'h0000_0100_0000_0800, 1'b1, "R7 mask above phys");
        issue(1'b0, 17, '0, 1'b0, "R7 R9 mask readback");
        issue(1'b1, 31, 64'h0000_0008_0000_0800, 1'b0, "R7 last mask legal");
        issue(1'b1, 30, 64'h0000_0008_0000_0001, 1'b0, "R6 last base legal");
        issue(1'b0, 31, '0, 1'b0, "R7 last mask readback");
        issue(1'b0, 30, '0, 1'b0, "R6 last base readback");

        // R8
        issue(1'b1, 1, 64'h0000_0000_0000_0C06, 1'b0, "R8 deftype legal");
        issue(1'b1, 1, 64'h0000_0000_0000_0106, 1'b1, "R8 deftype bit8");
        issue(1'b1, 1, 64'h0000_0001_0000_0006, 1'b1, "R8 deftype upper word");
        issue(1'b1, 1, 64'h0000_0000_0000_0002, 1'b1, "R8 deftype type 0x02");
        issue(1'b1, 1, 64'h0000_0000_0010_0000, 1'b1, "R8 deftype bit20");
        issue(1'b0, 1, '0, 1'b0, "R8 R9 deftype readback");

        // R10
        issue(1'b1, 6, 64'h0, 1'b1, "R10 unmapped write");
        issue(1'b0, 6, '0, 1'b1, "R10 unmapped read");
        issue(1'b1, 7, 64'h0606, 1'b1, "R10 unmapped write 7");

        // R2: idle gap then back-to-back write/read of same register
        idle(3);
        issue(1'b1, 20, 64'h0000_0001_2345_6005, 1'b0, "R2 write before read");
        issue(1'b0, 20, '0, 1'b0, "R2 read right after write");
        issue(1'b1, 20, 64'h0000_0001_2345_6F05, 1'b1, "R2 R9 reject before read");
        issue(1'b0, 20, '0, 1'b0, "R2 R9 read right after reject");
        idle(4);

        check(sb.size() == 0, "R2 responses outstanding", 64'(sb.size()), 1'b0, '0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule